// File: doc/BRIEF.md
# Branch Trail Buffer

The branch trail buffer keeps a rolling history of the last 32 taken control-flow changes so that profiling software can sample them. Each capture cycle presents the address the flow left, the address it went to, a 3-bit kind code, and the privilege level at each end. Two enable inputs select which privilege levels are recorded. The block masks what must not be recorded and writes the result into a circular store of source, target and info words.

Software reads a record through a registered read port. It gives a logical index and a word selector. Index 0 is always the most recent record, index 1 the one before it, and so on. An invalidate input drops every stored record at once, so nothing captured before it can be read back afterwards.

Top module: `branch_trail_buffer`

## Requirements
- R1: After reset, every index and every word selector reads zero, and `rd_valid` stays low until a read is requested.
- R2: A read requested in one cycle returns `rd_valid` high and its data in the next cycle. The data reflects the store as it stood before that edge. `rd_valid` is low in any cycle that follows a cycle with no request.
- R3: Word selector 0 returns the source address, 1 the target address, and 2 the info word. Selector 3 returns zero. The info word layout is: bit 0 source-valid, bit 1 target-valid, bits 4:2 kind, bits 6:5 source level, bits 8:7 target level, all higher bits zero.
- R4: Logical index 0 reads the newest record, and index k reads the record captured k captures earlier.
- R5: The store wraps after 32 records. Each new record overwrites the oldest, so after 40 captures index 31 holds the ninth capture.
- R6: Level 0 is enabled by `en_user`, level 1 by `en_kernel`, and levels 2 and 3 are never enabled. Kinds 0 to 3 are direct (0), indirect (1), call (2) and return (3). A record of one of these kinds is stored only when its source level is enabled, and then both valid flags are set. Kinds 6 and 7 are never stored.
- R7: An exception (kind 4) is stored when either its source level or its target level is enabled. Each valid flag equals the enable of its own level. An address whose flag is clear reads as zero.
- R8: An exception return (kind 5) follows the same rule as R7.
- R9: After an invalidate, every index reads zero on all selectors.
- R10: When a capture and an invalidate occur in the same cycle, the invalidate acts first. The new record is then at index 0, and index 1 reads zero.
- R11: An index that has not been written since reset or since the last invalidate reads zero on all selectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_user | input | 1 | Record level 0 |
| en_kernel | input | 1 | Record level 1 |
| cap_valid | input | 1 | A taken control-flow change is presented |
| cap_src | input | AW | Source address |
| cap_tgt | input | AW | Target address |
| cap_kind | input | 3 | Kind code (R6 to R8) |
| cap_src_lvl | input | 2 | Privilege level at the source |
| cap_tgt_lvl | input | 2 | Privilege level at the target |
| inval | input | 1 | Drop all records |
| rd_req | input | 1 | Read request |
| rd_idx | input | log2(DEPTH) | Logical index, 0 is newest |
| rd_sel | input | 2 | Word selector |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | AW | Read data |

## Verification
A capture or invalidate presented in a cycle takes effect at the next rising edge. A read request is sampled at the edge after that, and its data appears on the port one edge later. Every read result is therefore due exactly one cycle after its request. The bench drives inputs on the falling edge, so each capture lands on the rising edge that follows. It then raises the read request and samples `rd_valid` and `rd_data` on the next falling edge, half a cycle clear of the edge that updates them. Requests are never overlapped with their results.

// File: rtl/brt_pkg.sv
package brt_pkg;

  typedef enum logic [2:0] {
    BR_DIRECT   = 3'd0,
    BR_INDIRECT = 3'd1,
    BR_CALL     = 3'd2,
    BR_RETURN   = 3'd3,
    BR_EXC      = 3'd4,
    BR_ERET     = 3'd5
  } br_kind_e;

  // Packed MSB first: sv lands in bit 0.
  typedef struct packed {
    logic [1:0] tgt_lvl;
    logic [1:0] src_lvl;
    logic [2:0] kind;
    logic       tv;
    logic       sv;
  } rec_info_t;

  localparam int INFO_W = $bits(rec_info_t);

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_TGT  = 2'd1;
  localparam logic [1:0] SEL_INFO = 2'd2;

  function automatic logic lvl_on(input logic [1:0] lvl, input logic en_u,
                                  input logic en_k);
    return (lvl == 2'd0 && en_u) || (lvl == 2'd1 && en_k);
  endfunction

  function automatic logic kind_is_exc(input logic [2:0] k);
    return (k == BR_EXC) || (k == BR_ERET);
  endfunction

  function automatic logic kind_known(input logic [2:0] k);
    return k <= BR_ERET;
  endfunction

endpackage

// File: rtl/brt_filter.sv
module brt_filter
  import brt_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          cap_valid,
  input  logic [AW-1:0] cap_src,
  input  logic [AW-1:0] cap_tgt,
  input  logic [2:0]    cap_kind,
  input  logic [1:0]    cap_src_lvl,
  input  logic [1:0]    cap_tgt_lvl,
  input  logic          en_user,
  input  logic          en_kernel,
  output logic          accept,
  output rec_info_t     info,
  output logic [AW-1:0] src_m,
  output logic [AW-1:0] tgt_m
);

  logic s_on, t_on, exc, sv, tv;

  always_comb begin
    s_on = lvl_on(cap_src_lvl, en_user, en_kernel);
    t_on = lvl_on(cap_tgt_lvl, en_user, en_kernel);
    exc  = kind_is_exc(cap_kind);
    sv   = s_on;
    tv   = exc ? t_on : s_on;
    accept = cap_valid && kind_known(cap_kind) && (exc ? (s_on || t_on) : s_on);
    info.sv      = sv;
    info.tv      = tv;
    info.kind    = cap_kind;
    info.src_lvl = cap_src_lvl;
    info.tgt_lvl = cap_tgt_lvl;
    src_m = sv ? cap_src : '0;
    tgt_m = tv ? cap_tgt : '0;
  end

endmodule

// File: rtl/brt_store.sv
module brt_store
  import brt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             inval,
  input  logic [AW-1:0]    wr_src,
  input  logic [AW-1:0]    wr_tgt,
  input  rec_info_t        wr_info,
  input  logic [IDX_W-1:0] rd_slot,
  output logic [AW-1:0]    rd_src,
  output logic [AW-1:0]    rd_tgt,
  output rec_info_t        rd_info,
  output logic             rd_hit,
  output logic [IDX_W-1:0] wp,
  output logic [DEPTH-1:0] vld_vec
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [AW-1:0] src_mem [DEPTH];
  logic [AW-1:0] tgt_mem [DEPTH];
  rec_info_t     info_mem[DEPTH];

  function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wp <= '0;
    else if (wr_en) wp <= ptr_next(wp);
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      src_mem[wp]  <= wr_src;
      tgt_mem[wp]  <= wr_tgt;
      info_mem[wp] <= wr_info;
    end
  end

  // Per-slot valid: a write to the slot wins over invalidate.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic v_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            v_q <= 1'b0;
      else if (wr_en && wp == IDX_W'(g))     v_q <= 1'b1;
      else if (inval)                        v_q <= 1'b0;
    end
    assign vld_vec[g] = v_q;
  end

  assign rd_src  = src_mem[rd_slot];
  assign rd_tgt  = tgt_mem[rd_slot];
  assign rd_info = info_mem[rd_slot];
  assign rd_hit  = vld_vec[rd_slot];

endmodule

// File: rtl/brt_readport.sv
module brt_readport
  import brt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [1:0]       rd_sel,
  input  logic [IDX_W-1:0] wp,
  output logic [IDX_W-1:0] rd_slot,
  input  logic [AW-1:0]    slot_src,
  input  logic [AW-1:0]    slot_tgt,
  input  rec_info_t        slot_info,
  input  logic             slot_hit,
  output logic             rd_valid,
  output logic [AW-1:0]    rd_data
);

  // Newest record sits one slot behind the write pointer.
  function automatic logic [IDX_W-1:0] newest_slot(input logic [IDX_W-1:0] ptr,
                                                   input logic [IDX_W-1:0] idx);
    int s;
    s = int'(ptr) + DEPTH - 1 - int'(idx);
    if (s >= DEPTH) s = s - DEPTH;
    return IDX_W'(s);
  endfunction

  logic          in_range;
  logic [AW-1:0] word;

  always_comb begin
    rd_slot  = newest_slot(wp, rd_idx);
    in_range = int'(rd_idx) < DEPTH;
    word     = '0;
    if (slot_hit && in_range) begin
      case (rd_sel)
        SEL_SRC:  word = slot_src;
        SEL_TGT:  word = slot_tgt;
        SEL_INFO: word = AW'(slot_info);
        default:  word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= word;
    end
  end

endmodule

// File: rtl/branch_trail_buffer.sv
module branch_trail_buffer
  import brt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_user,
  input  logic             en_kernel,
  input  logic             cap_valid,
  input  logic [AW-1:0]    cap_src,
  input  logic [AW-1:0]    cap_tgt,
  input  logic [2:0]       cap_kind,
  input  logic [1:0]       cap_src_lvl,
  input  logic [1:0]       cap_tgt_lvl,
  input  logic             inval,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [1:0]       rd_sel,
  output logic             rd_valid,
  output logic [AW-1:0]    rd_data
);

  // Named internal events, observed by the bound checker.
  logic             cap_accept;
  rec_info_t        cap_info;
  logic [AW-1:0]    cap_src_m, cap_tgt_m;
  logic [IDX_W-1:0] wr_ptr, rd_slot;
  logic [DEPTH-1:0] slot_vld;
  logic [AW-1:0]    slot_src, slot_tgt;
  rec_info_t        slot_info;
  logic             slot_hit;

  brt_filter #(.AW(AW)) u_filter (
    .cap_valid  (cap_valid),
    .cap_src    (cap_src),
    .cap_tgt    (cap_tgt),
    .cap_kind   (cap_kind),
    .cap_src_lvl(cap_src_lvl),
    .cap_tgt_lvl(cap_tgt_lvl),
    .en_user    (en_user),
    .en_kernel  (en_kernel),
    .accept     (cap_accept),
    .info       (cap_info),
    .src_m      (cap_src_m),
    .tgt_m      (cap_tgt_m)
  );

  brt_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cap_accept),
    .inval  (inval),
    .wr_src (cap_src_m),
    .wr_tgt (cap_tgt_m),
    .wr_info(cap_info),
    .rd_slot(rd_slot),
    .rd_src (slot_src),
    .rd_tgt (slot_tgt),
    .rd_info(slot_info),
    .rd_hit (slot_hit),
    .wp     (wr_ptr),
    .vld_vec(slot_vld)
  );

  brt_readport #(.DEPTH(DEPTH), .AW(AW)) u_rport (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_idx   (rd_idx),
    .rd_sel   (rd_sel),
    .wp       (wr_ptr),
    .rd_slot  (rd_slot),
    .slot_src (slot_src),
    .slot_tgt (slot_tgt),
    .slot_info(slot_info),
    .slot_hit (slot_hit),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_user,
  input logic             en_kernel,
  input logic [2:0]       cap_kind,
  input logic             cap_accept,
  input logic             inval,
  input logic             rd_req,
  input logic             rd_valid,
  input logic [IDX_W-1:0] wr_ptr,
  input logic [DEPTH-1:0] slot_vld
);

  p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  p_ptr_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_accept |=> wr_ptr != $past(wr_ptr));

  p_ptr_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_accept |=> $stable(wr_ptr));

  p_slot_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_accept |=> slot_vld[$past(wr_ptr)]);

  p_none_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_user && !en_kernel) |-> !cap_accept);

  p_reserved_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_kind > 3'd5) |-> !cap_accept);

  p_inval_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inval && !cap_accept) |=> slot_vld == '0);

  p_inval_cap_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inval && cap_accept) |=> $countones(slot_vld) == 1);

endmodule

bind branch_trail_buffer brt_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_user   (en_user),
  .en_kernel (en_kernel),
  .cap_kind  (cap_kind),
  .cap_accept(cap_accept),
  .inval     (inval),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .wr_ptr    (wr_ptr),
  .slot_vld  (slot_vld)
);

// File: tb/branch_trail_buffer_tb.sv
module branch_trail_buffer_tb;

  localparam int DEPTH = 32;
  localparam int AW    = 64;
  localparam int IDX_W = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en_user = 1'b0, en_kernel = 1'b0;
  logic             cap_valid = 1'b0;
  logic [AW-1:0]    cap_src = '0, cap_tgt = '0;
  logic [2:0]       cap_kind = '0;
  logic [1:0]       cap_src_lvl = '0, cap_tgt_lvl = '0;
  logic             inval = 1'b0;
  logic             rd_req = 1'b0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [1:0]       rd_sel = '0;
  logic             rd_valid;
  logic [AW-1:0]    rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  branch_trail_buffer #(.DEPTH(DEPTH), .AW(AW)) u_dut (.*);

  // Vector: {kind[11:9], src_lvl[8:7], tgt_lvl[6:5], en_u[4], en_k[3], acc[2], sv[1], tv[0]}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    12'b000_00_00_1_0_1_1_1,
    12'b000_00_00_0_1_0_0_0,
    12'b001_01_01_0_1_1_1_1,
    12'b010_10_10_1_1_0_0_0,
    12'b100_00_01_1_0_1_1_0,
    12'b100_00_01_0_1_1_0_1,
    12'b100_00_10_1_1_1_1_0,
    12'b100_10_11_1_1_0_0_0,
    12'b101_01_00_1_0_1_0_1,
    12'b101_01_00_0_1_1_1_0,
    12'b011_01_01_1_1_1_1_1,
    12'b110_00_00_1_1_0_0_0
  };

  function automatic logic [AW-1:0] mk_info(input logic sv, input logic tv,
      input logic [2:0] k, input logic [1:0] sl, input logic [1:0] tl);
    logic [AW-1:0] w;
    w = '0;
    w[0] = sv;
    w[1] = tv;
    w[4:2] = k;
    w[6:5] = sl;
    w[8:7] = tl;
    return w;
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] got,
                       input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_cap(input logic [AW-1:0] s, input logic [AW-1:0] t,
      input logic [2:0] k, input logic [1:0] sl, input logic [1:0] tl,
      input logic inv);
    @(negedge clk);
    cap_valid = 1'b1; cap_src = s; cap_tgt = t; cap_kind = k;
    cap_src_lvl = sl; cap_tgt_lvl = tl; inval = inv;
    @(negedge clk);
    cap_valid = 1'b0; inval = 1'b0;
  endtask

  task automatic do_inval();
    @(negedge clk);
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
  endtask

  task automatic rd(input int idx, input logic [1:0] sel,
                    output logic [AW-1:0] d, output logic v);
    @(negedge clk);
    rd_req = 1'b1; rd_idx = IDX_W'(idx); rd_sel = sel;
    @(negedge clk);
    d = rd_data; v = rd_valid;
    rd_req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int idx, input logic [1:0] sel,
                        input logic [AW-1:0] exp);
    logic [AW-1:0] d;
    logic v;
    rd(idx, sel, d, v);
    check(tag, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] d;
    logic v;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rd_valid idle", {63'b0, rd_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_valid after reset", {63'b0, rd_valid}, '0);
    rd_chk("R1 idx0 src", 0, 2'd0, '0);
    rd_chk("R1 idx5 info", 5, 2'd2, '0);
    rd_chk("R1 idx31 tgt", 31, 2'd1, '0);

    // Vector table: R6, R7, R8 filtering and masking
    for (int i = 0; i < NV; i++) begin
      logic [11:0] vv;
      logic [AW-1:0] s, t;
      string tag;
      vv = VEC[i];
      s = 64'h1000_0000 + AW'(i * 16);
      t = 64'h2000_0000 + AW'(i * 16);
      tag = (vv[11:9] == 3'd4) ? "R7" : (vv[11:9] == 3'd5) ? "R8" : "R6";
      en_user = vv[4]; en_kernel = vv[3];
      do_inval();
      do_cap(s, t, vv[11:9], vv[8:7], vv[6:5], 1'b0);
      rd_chk({tag, " vec src"}, 0, 2'd0, vv[1] ? s : '0);
      rd_chk({tag, " vec tgt"}, 0, 2'd1, vv[0] ? t : '0);
      rd_chk({tag, " vec info"}, 0, 2'd2,
             vv[2] ? mk_info(vv[1], vv[0], vv[11:9], vv[8:7], vv[6:5]) : '0);
    end

    // R2: latency and idle
    en_user = 1'b1; en_kernel = 1'b1;
    rd(0, 2'd0, d, v);
    check("R2 rd_valid high", {63'b0, v}, 64'd1);
    @(negedge clk);
    check("R2 rd_valid low", {63'b0, rd_valid}, '0);

    // R4, R11: newest-first
    do_inval();
    for (int i = 0; i < 5; i++)
      do_cap(64'h5000 + AW'(i), 64'h6000 + AW'(i), 3'(i % 4), 2'd0, 2'd0, 1'b0);
    for (int k = 0; k < 5; k++)
      rd_chk("R4 newest-first src", k, 2'd0, 64'h5000 + AW'(4 - k));
    rd_chk("R4 idx2 tgt", 2, 2'd1, 64'h6002);
    rd_chk("R11 unwritten idx5 info", 5, 2'd2, '0);
    rd_chk("R11 unwritten idx31 src", 31, 2'd0, '0);

    // R3: selector 3 and info word
    rd_chk("R3 sel3 zero", 0, 2'd3, '0);
    rd_chk("R3 info idx0", 0, 2'd2, mk_info(1'b1, 1'b1, 3'd0, 2'd0, 2'd0));

    // R5: wrap after 40 captures
    do_inval();
    for (int i = 0; i < 40; i++)
      do_cap(64'hA000 + AW'(i), 64'hB000, 3'd1, 2'd1, 2'd1, 1'b0);
    rd_chk("R5 wrap idx0", 0, 2'd0, 64'hA000 + 64'd39);
    rd_chk("R5 wrap idx15", 15, 2'd0, 64'hA000 + 64'd24);
    rd_chk("R5 wrap idx31", 31, 2'd0, 64'hA000 + 64'd8);

    // R9: invalidate
    do_inval();
    rd_chk("R9 idx0 src", 0, 2'd0, '0);
    rd_chk("R9 idx0 info", 0, 2'd2, '0);
    rd_chk("R9 idx31 tgt", 31, 2'd1, '0);

    // R10: capture together with invalidate
    for (int i = 0; i < 3; i++)
      do_cap(64'hC000 + AW'(i), 64'hD000, 3'd2, 2'd0, 2'd0, 1'b0);
    do_cap(64'hBEEF, 64'hFEED, 3'd3, 2'd1, 2'd1, 1'b1);
    rd_chk("R10 new at idx0", 0, 2'd0, 64'hBEEF);
    rd_chk("R10 idx1 src", 1, 2'd0, '0);
    rd_chk("R10 idx1 info", 1, 2'd2, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule